// File: doc/BRIEF.md
# Condition code register controller

This block keeps the 8-bit flag register of a small 8-bit processor core and applies the flag-related side effects of a handful of operation classes. An add-type operation updates the half-carry, sign, zero, overflow and carry flags from its two operands and carry-in. An accumulator transfer or an interrupt-return restore loads the register from a supplied byte, except that the pin-interrupt mask can only be cleared this way and never set. The mask is set only by reset or by the stacking-done strobe that acknowledges the pin interrupt. That strobe also sets the ordinary interrupt mask.

The block also gates the non-maskable interrupt pin with the mask to give a pending flag. It decides whether a STOP operation enters low-power mode or is demoted to a no-op, which depends on the stop-disable bit. The register layout, from bit 7 down to bit 0, is: stop-disable S, pin mask X, half-carry H, interrupt mask I, sign N, zero Z, overflow V, carry C.

The core's sequencer presents one operation class per clock on a one-hot code. All results appear one clock later on registered outputs.

Top module: `ccr_ctrl`

## Requirements
- R1: While reset is active and after it is released, the register reads 0xD0 (S, X and I at 1, all other bits 0), and `irq_pend`, `stop_enter` and `stop_nop` are 0.
- R2: On an add operation (`op_class` = 5'b00001), H becomes the carry out of bit 3 of the sum `opnd_a + opnd_b + carry_in`: 1 if such a carry occurs and 0 otherwise.
- R3: On an add operation, the flags are set from the 8-bit result and carry-out as follows: N is result bit 7, Z is 1 when the result is zero, V is the two's-complement overflow, and C is the carry out of bit 7.
- R4: An add operation leaves S, X and I unchanged.
- R5: A transfer (`op_class` = 5'b00010) or a restore (5'b00100) loads every bit except bit 6 from `load_byte`. Bit 6 (X) becomes 0 when `load_byte[6]` is 0 and otherwise keeps its old value, so it never goes from 0 to 1.
- R6: A cycle with `stack_done` high makes X and I both 1 in the next cycle, whatever operation is presented in the same cycle. No other input can set X.
- R7: `irq_pend` is registered every clock as `nmi_pin` AND NOT X, where X is the value the register holds after the same clock edge.
- R8: A STOP operation (5'b01000) while S is 0 raises `stop_enter` for exactly the next cycle, keeps `stop_nop` low and leaves the register unchanged.
- R9: A STOP operation while S is 1 raises `stop_nop` for the next cycle, keeps `stop_enter` low and leaves the register unchanged.
- R10: An other-class operation (5'b10000) or an idle cycle (all zero) leaves the whole register, including H, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_class | input | 5 | One-hot operation class: bit0 add, bit1 transfer, bit2 restore, bit3 STOP, bit4 other; zero is idle |
| opnd_a | input | DW (8) | First add operand |
| opnd_b | input | DW (8) | Second add operand |
| carry_in | input | 1 | Carry into the add (0 for plain adds) |
| load_byte | input | 8 | Byte for transfer or restore |
| nmi_pin | input | 1 | Non-maskable interrupt pin level |
| stack_done | input | 1 | Strobe: registers stacked for the pin interrupt |
| ccr_out | output | 8 | Condition code register S X H I N Z V C |
| irq_pend | output | 1 | Pin interrupt pending, gated by X |
| stop_enter | output | 1 | One-cycle request to enter low-power stop |
| stop_nop | output | 1 | STOP was executed as a no-op |

## Verification
The assertions take for granted that `op_class` has at most one bit set in each cycle; this is also checked as an input rule. The stability and mask properties rely on the only register-changing inputs being the add, transfer and restore classes and the stacking-done strobe. The stimulus drives every input on the falling clock edge from a table that uses only the five legal codes and zero. The one cycle where `stack_done` coincides with a restore is set up on purpose, to exercise the priority of the acknowledge.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    localparam int CCR_W    = 8;
    localparam int OPC_W    = 5;

    // bit positions inside the register (layout S X H I N Z V C)
    localparam int BIT_C    = 0;
    localparam int BIT_V    = 1;
    localparam int BIT_Z    = 2;
    localparam int BIT_N    = 3;
    localparam int BIT_I    = 4;
    localparam int BIT_H    = 5;
    localparam int BIT_X    = 6;
    localparam int BIT_S    = 7;

    // one-hot operation class bit positions
    localparam int OPB_ADD  = 0;
    localparam int OPB_XFER = 1;
    localparam int OPB_RTI  = 2;
    localparam int OPB_STOP = 3;
    localparam int OPB_OTH  = 4;

    localparam logic [CCR_W-1:0] CCR_RST = 8'hD0;

    typedef struct packed {
        logic s;
        logic x;
        logic h;
        logic i;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    typedef struct packed {
        ccr_t flags;
        logic pend;
        logic stop_go;
        logic stop_nop;
    } ctl_state_t;

    typedef struct packed {
        logic h;
        logic n;
        logic z;
        logic v;
        logic c;
    } add_flags_t;

endpackage

// File: rtl/ccr_add_flags.sv
module ccr_add_flags
    import ccr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic          carry_in,
    output add_flags_t    flags
);
    localparam int HC_IDX = DW / 2 - 1;
    localparam int MSB    = DW - 1;

    logic [DW:0]   sum_w;
    logic [DW-1:0] res;

    always_comb begin
        sum_w = {1'b0, opnd_a} + {1'b0, opnd_b} + {{DW{1'b0}}, carry_in};
        res   = sum_w[DW-1:0];

        // carry out of the lower half, rebuilt from operands and result
        flags.h = (opnd_a[HC_IDX] & opnd_b[HC_IDX])
                | (opnd_b[HC_IDX] & ~res[HC_IDX])
                | (~res[HC_IDX]   & opnd_a[HC_IDX]);
        flags.n = res[MSB];
        flags.z = (res == '0);
        flags.v = (opnd_a[MSB] & opnd_b[MSB] & ~res[MSB])
                | (~opnd_a[MSB] & ~opnd_b[MSB] & res[MSB]);
        flags.c = sum_w[DW];
    end

endmodule

// File: rtl/ccr_load_merge.sv
module ccr_load_merge
    import ccr_pkg::*;
(
    input  logic [CCR_W-1:0] cur,
    input  logic [CCR_W-1:0] load_byte,
    output logic [CCR_W-1:0] merged
);
    for (genvar g = 0; g < CCR_W; g++) begin : g_bit
        if (g == BIT_X) begin : g_mask
            // software may only clear the pin mask
            assign merged[g] = cur[g] & load_byte[g];
        end else begin : g_copy
            assign merged[g] = load_byte[g];
        end
    end

endmodule

// File: rtl/ccr_stop_gate.sv
module ccr_stop_gate (
    input  logic op_stop,
    input  logic stop_dis,
    output logic go,
    output logic nop
);
    always_comb begin
        go  = op_stop & ~stop_dis;
        nop = op_stop &  stop_dis;
    end

endmodule

// File: rtl/ccr_ctrl.sv
module ccr_ctrl
    import ccr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [4:0]       op_class,
    input  logic [DW-1:0]    opnd_a,
    input  logic [DW-1:0]    opnd_b,
    input  logic             carry_in,
    input  logic [7:0]       load_byte,
    input  logic             nmi_pin,
    input  logic             stack_done,
    output logic [7:0]       ccr_out,
    output logic             irq_pend,
    output logic             stop_enter,
    output logic             stop_nop
);
    ctl_state_t  st_d, st_q;
    add_flags_t  add_f;
    logic [CCR_W-1:0] merged;
    logic        stop_go_w, stop_nop_w;

    ccr_add_flags #(.DW(DW)) add_i (
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .carry_in (carry_in),
        .flags    (add_f)
    );

    ccr_load_merge merge_i (
        .cur       (st_q.flags),
        .load_byte (load_byte),
        .merged    (merged)
    );

    ccr_stop_gate stop_i (
        .op_stop  (op_class[OPB_STOP]),
        .stop_dis (st_q.flags.s),
        .go       (stop_go_w),
        .nop      (stop_nop_w)
    );

    always_comb begin
        st_d = st_q;

        if (op_class[OPB_ADD]) begin
            st_d.flags.h = add_f.h;
            st_d.flags.n = add_f.n;
            st_d.flags.z = add_f.z;
            st_d.flags.v = add_f.v;
            st_d.flags.c = add_f.c;
        end else if (op_class[OPB_XFER] || op_class[OPB_RTI]) begin
            st_d.flags = ccr_t'(merged);
        end

        // acknowledge of the pin interrupt wins over any load
        if (stack_done) begin
            st_d.flags.x = 1'b1;
            st_d.flags.i = 1'b1;
        end

        st_d.pend     = nmi_pin & ~st_d.flags.x;
        st_d.stop_go  = stop_go_w;
        st_d.stop_nop = stop_nop_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flags    <= ccr_t'(CCR_RST);
            st_q.pend     <= 1'b0;
            st_q.stop_go  <= 1'b0;
            st_q.stop_nop <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ccr_out    = st_q.flags;
    assign irq_pend   = st_q.pend;
    assign stop_enter = st_q.stop_go;
    assign stop_nop   = st_q.stop_nop;

endmodule

// File: rtl/ccr_ctrl_chk.sv
module ccr_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] op_class,
    input logic [7:0] load_byte,
    input logic       stack_done,
    input logic [7:0] ccr_out,
    input logic       irq_pend,
    input logic       stop_enter,
    input logic       stop_nop
);
    // input rule: at most one operation class per cycle
    AST_OP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(op_class));

    AST_X_SW_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ccr_out[6]) |-> ($past(op_class[1]) || $past(op_class[2])) && !$past(load_byte[6])); // R5

    AST_X_SET_BY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ccr_out[6]) |-> $past(stack_done)); // R6

    AST_ACK_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        stack_done |=> ccr_out[6] && ccr_out[4]); // R6

    AST_PEND_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pend |-> !ccr_out[6]); // R7

    AST_STOP_GO: assert property (@(posedge clk) disable iff (!rst_n)
        stop_enter |-> $past(op_class[3]) && !$past(ccr_out[7])); // R8

    AST_STOP_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        stop_nop |-> $past(op_class[3]) && $past(ccr_out[7])); // R9

    AST_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(stop_enter && stop_nop)); // R9

    AST_ADD_KEEPS_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_class[0]) && !$past(stack_done) |->
            (ccr_out[7] == $past(ccr_out[7])) && (ccr_out[6] == $past(ccr_out[6]))
            && (ccr_out[4] == $past(ccr_out[4]))); // R4

    AST_HOLD_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(op_class[2:0]) == 3'b000) && !$past(stack_done) |-> $stable(ccr_out)); // R10

endmodule

bind ccr_ctrl ccr_ctrl_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_class   (op_class),
    .load_byte  (load_byte),
    .stack_done (stack_done),
    .ccr_out    (ccr_out),
    .irq_pend   (irq_pend),
    .stop_enter (stop_enter),
    .stop_nop   (stop_nop)
);

// File: tb/ccr_ctrl_tb.sv
module ccr_ctrl_tb_top;

    localparam logic [4:0] C_IDLE = 5'b00000;
    localparam logic [4:0] C_ADD  = 5'b00001;
    localparam logic [4:0] C_XFR  = 5'b00010;
    localparam logic [4:0] C_RTI  = 5'b00100;
    localparam logic [4:0] C_STP  = 5'b01000;
    localparam logic [4:0] C_OTH  = 5'b10000;

    typedef struct packed {
        logic [4:0] op;
        logic [7:0] a;
        logic [7:0] b;
        logic       cin;
        logic [7:0] byt;
        logic       pin;
        logic       ack;
        logic [7:0] e_ccr;
        logic       e_pend;
        logic       e_go;
        logic       e_nop;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{C_ADD,  8'h08, 8'h08, 1'b0, 8'h00, 1'b0, 1'b0, 8'hF0, 1'b0, 1'b0, 1'b0},
        '{C_ADD,  8'h80, 8'h80, 1'b0, 8'h00, 1'b0, 1'b0, 8'hD7, 1'b0, 1'b0, 1'b0},
        '{C_ADD,  8'h7F, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0, 8'hFA, 1'b0, 1'b0, 1'b0},
        '{C_XFR,  8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        '{C_RTI,  8'h00, 8'h00, 1'b0, 8'hFF, 1'b1, 1'b0, 8'hBF, 1'b1, 1'b0, 1'b0},
        '{C_OTH,  8'h33, 8'hCC, 1'b1, 8'h00, 1'b1, 1'b0, 8'hBF, 1'b1, 1'b0, 1'b0},
        '{C_ADD,  8'h0F, 8'h01, 1'b0, 8'h00, 1'b1, 1'b0, 8'hB0, 1'b1, 1'b0, 1'b0},
        '{C_STP,  8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 8'hB0, 1'b0, 1'b0, 1'b1},
        '{C_XFR,  8'h00, 8'h00, 1'b0, 8'h40, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        '{C_STP,  8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0},
        '{C_IDLE, 8'h00, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 8'h50, 1'b0, 1'b0, 1'b0},
        '{C_RTI,  8'h00, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},
        '{C_ADD,  8'h07, 8'h08, 1'b1, 8'h00, 1'b0, 1'b0, 8'h20, 1'b0, 1'b0, 1'b0},
        '{C_ADD,  8'h01, 8'h02, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op_class = '0;
    logic [7:0] opnd_a = '0;
    logic [7:0] opnd_b = '0;
    logic       carry_in = 1'b0;
    logic [7:0] load_byte = '0;
    logic       nmi_pin = 1'b0;
    logic       stack_done = 1'b0;
    logic [7:0] ccr_out;
    logic       irq_pend;
    logic       stop_enter;
    logic       stop_nop;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ccr_ctrl #(.DW(8)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_class   (op_class),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .carry_in   (carry_in),
        .load_byte  (load_byte),
        .nmi_pin    (nmi_pin),
        .stack_done (stack_done),
        .ccr_out    (ccr_out),
        .irq_pend   (irq_pend),
        .stop_enter (stop_enter),
        .stop_nop   (stop_nop)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [4:0] op, input logic ack);
        if (ack) return "R6";
        case (op)
            C_ADD:        return "R2 R3 R4";
            C_XFR, C_RTI: return "R5";
            C_STP:        return "R8 R9";
            default:      return "R10";
        endcase
    endfunction

    task automatic drive(input vec_t v);
        op_class   = v.op;
        opnd_a     = v.a;
        opnd_b     = v.b;
        carry_in   = v.cin;
        load_byte  = v.byt;
        nmi_pin    = v.pin;
        stack_done = v.ack;
    endtask

    task automatic check_reset_state(input string what);
        chk({"R1 ccr ", what}, ccr_out, 8'hD0);
        chk({"R1 pend ", what}, {7'd0, irq_pend}, 8'h00);
        chk({"R1 go ", what}, {7'd0, stop_enter}, 8'h00);
        chk({"R1 nop ", what}, {7'd0, stop_nop}, 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state("during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state("after release");

        // table walk: drive on falling edge, result registered at the next rising edge
        for (int k = 0; k < NV; k++) begin
            drive(VEC[k]);
            @(posedge clk);
            @(negedge clk);
            chk({"ccr ", tag_of(VEC[k].op, VEC[k].ack)}, ccr_out, VEC[k].e_ccr);
            chk("R7 pend", {7'd0, irq_pend}, {7'd0, VEC[k].e_pend});
            chk("R8 stop_enter", {7'd0, stop_enter}, {7'd0, VEC[k].e_go});
            chk("R9 stop_nop", {7'd0, stop_nop}, {7'd0, VEC[k].e_nop});
        end

        // R6: acknowledge together with a restore of 0x00 keeps X and I set
        drive('{C_RTI, 8'h00, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0});
        @(posedge clk);
        @(negedge clk);
        chk("R6 ack beats restore", ccr_out, 8'h50);
        chk("R7 pend masked by ack", {7'd0, irq_pend}, 8'h00);

        // R5: transfer with bit 6 set cannot raise X once cleared; first clear it
        drive('{C_XFR, 8'h00, 8'h00, 1'b0, 8'h2F, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0});
        @(posedge clk);
        @(negedge clk);
        chk("R5 clear X via transfer", ccr_out, 8'h2F);
        drive('{C_XFR, 8'h00, 8'h00, 1'b0, 8'hC0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0});
        @(posedge clk);
        @(negedge clk);
        chk("R5 X stays clear", ccr_out, 8'h80);

        // R8: back to idle, stop request lasts one cycle (S now 1 -> nop path first)
        drive('{C_STP, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0});
        @(posedge clk);
        @(negedge clk);
        chk("R9 nop with S set", {6'd0, stop_enter, stop_nop}, 8'h01);
        drive('{C_IDLE, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0});
        @(posedge clk);
        @(negedge clk);
        chk("R8 flags drop after one cycle", {6'd0, stop_enter, stop_nop}, 8'h00);
        chk("R10 idle keeps ccr", ccr_out, 8'h80);

        // R1: reset in mid-run restores the reset state
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state("mid-run");
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state("mid-run release");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule